// File: doc/BRIEF.md
# Page Request Event Reporter

This block sits on the application side of a PCI Express endpoint that can ask the host to map pages. It serves up to eight functions. For each function it tracks which page request groups are still awaiting a response, and it classifies each incoming group response. From these it raises three kinds of event: a failed response, a response whose group index was never requested, and a stop-complete condition. Stop-complete means the function has had its page request enable withdrawn and all of its requests have been answered.

Events are kept as sticky per-function, per-kind flags. A round-robin picker turns them into one serial event port. That port carries a one-cycle valid strobe together with a function number and a two-bit event code. Function number and code are meaningful only while the strobe is high. The port serves endpoint operation only and runs in the single (slow) clock domain of the block.

Top module: `prs_event_reporter`

## Requirements
- R1: A low `rst_n` at a clock edge clears all tracking state and pending events, and `evt_valid` is low in the cycle after such an edge.
- R2: `evt_valid` never stays high for two consecutive cycles, so every pulse lasts one cycle and is followed by at least one idle cycle.
- R3: `evt_code` uses these encodings: 2'b00 for a failed response, 2'b01 for an unexpected group index and 2'b10 for stop-complete. The value 2'b11 never appears with `evt_valid`, and `evt_func` is the function number 0 to 7.
- R4: A request `issue_valid` adds `issue_grp` to the open set of `issue_func`. A request for a group already open is ignored. A response for an open group removes it. A response and a request in the same cycle for the same function and group leave that group open.
- R5: A response with `resp_fail` high for an open group produces one code 2'b00 event for that function and closes the group.
- R6: A response whose group is not open produces one code 2'b01 event for that function. `resp_fail` has no effect on it and the open set is unchanged.
- R7: After a function's `func_enable` bit goes from 1 to 0, exactly one code 2'b10 event is produced once that function's open set is empty while the bit is still 0. No such event is produced while any group is open.
- R8: Code 2'b10 is produced at most once per falling edge of the enable bit. It is discarded if the bit is set again before it is reported, and it is never reported when the bit was high in the cycle before the pulse.
- R9: Repeated occurrences of the same event kind for the same function merge into a single pulse while one is already waiting.
- R10: When the port is idle, the next pulse goes to the first function with a waiting event, searching upward (with wrap) from the function after the last one reported. Function 0 is searched first after reset. Within a function, code 2'b00 goes before 2'b01, and 2'b01 goes before 2'b10. A pulse appears in the cycle after the event is registered, provided the port is free and the function wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A page request group is issued this cycle |
| issue_func | input | 3 | Function issuing the request |
| issue_grp | input | 3 | Group index of the issued request |
| resp_valid | input | 1 | A group response is received this cycle |
| resp_func | input | 3 | Function the response is addressed to |
| resp_grp | input | 3 | Group index carried by the response |
| resp_fail | input | 1 | Response reports failure |
| func_enable | input | 8 | Per-function page request enable bits |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_func | output | 3 | Function number of the event |
| evt_code | output | 2 | Event kind |

## Verification
The bench targets several corner cases:
- A stop-complete condition with a group still open. A design that reports early would pulse before the last response arrives.
- Re-enabling before the stop event is reported. A design without the discard would emit a stale code 2'b10 while the function is enabled again.
- Duplicate requests for the same group. A design that counts them would treat the second response as expected instead of unexpected.
- Back-to-back identical events while the port is busy. These must merge, and the bench checks the round-robin order, so a wrong pointer update shows up as a function-number mismatch.

// File: rtl/prs_evt_pkg.sv
package prs_evt_pkg;

    typedef enum logic [1:0] {
        EVT_RSP_FAIL  = 2'b00,
        EVT_BAD_GROUP = 2'b01,
        EVT_STOP_DONE = 2'b10
    } evt_code_e;

    localparam int KIND_FAIL = 0;
    localparam int KIND_BAD  = 1;
    localparam int KIND_STOP = 2;
    localparam int NUM_KINDS = 3;

    // Highest priority kind among waiting flags: fail, then bad group, then stop.
    function automatic evt_code_e pick_kind(input logic [NUM_KINDS-1:0] flags);
        if (flags[KIND_FAIL])     return EVT_RSP_FAIL;
        else if (flags[KIND_BAD]) return EVT_BAD_GROUP;
        else                      return EVT_STOP_DONE;
    endfunction

    function automatic logic [NUM_KINDS-1:0] kind_onehot(input evt_code_e code);
        logic [NUM_KINDS-1:0] v;
        v = '0;
        case (code)
            EVT_RSP_FAIL:  v[KIND_FAIL] = 1'b1;
            EVT_BAD_GROUP: v[KIND_BAD]  = 1'b1;
            default:       v[KIND_STOP] = 1'b1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/prs_func_tracker.sv
module prs_func_tracker
    import prs_evt_pkg::*;
#(
    parameter int GRP_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_hit,
    input  logic [GRP_W-1:0]     req_grp,
    input  logic                 rsp_hit,
    input  logic [GRP_W-1:0]     rsp_grp,
    input  logic                 rsp_fail,
    input  logic                 enable,
    input  logic [NUM_KINDS-1:0] clr,
    output logic [NUM_KINDS-1:0] pend
);
    localparam int SLOTS = 1 << GRP_W;
    localparam int CNT_W = GRP_W + 1;

    typedef struct packed {
        logic [SLOTS-1:0]     open;
        logic [CNT_W-1:0]     cnt;
        logic                 en_q;
        logic                 armed;
        logic [NUM_KINDS-1:0] flags;
    } trk_state_t;

    trk_state_t st_d, st_q;
    logic       rsp_match, rsp_bad, req_eff, en_fall;
    logic [SLOTS-1:0] open_mid;

    always_comb begin
        st_d      = st_q;
        rsp_match = rsp_hit && st_q.open[rsp_grp];
        rsp_bad   = rsp_hit && !st_q.open[rsp_grp];
        open_mid  = st_q.open;
        if (rsp_match) open_mid[rsp_grp] = 1'b0;
        req_eff   = req_hit && !open_mid[req_grp];
        if (req_eff) open_mid[req_grp] = 1'b1;
        st_d.open = open_mid;
        st_d.cnt  = st_q.cnt + {{(CNT_W-1){1'b0}}, req_eff}
                             - {{(CNT_W-1){1'b0}}, rsp_match};

        st_d.flags = st_q.flags & ~clr;
        if (rsp_match && rsp_fail) st_d.flags[KIND_FAIL] = 1'b1;
        if (rsp_bad)               st_d.flags[KIND_BAD]  = 1'b1;

        en_fall   = st_q.en_q && !enable;
        st_d.en_q = enable;
        if (enable) begin
            st_d.armed           = 1'b0;
            st_d.flags[KIND_STOP] = 1'b0;
        end else if ((st_q.armed || en_fall) && st_d.cnt == '0) begin
            st_d.armed           = 1'b0;
            st_d.flags[KIND_STOP] = 1'b1;
        end else if (en_fall) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = {st_q.flags[KIND_STOP] & ~enable, st_q.flags[KIND_BAD], st_q.flags[KIND_FAIL]};

endmodule

// File: rtl/prs_rr_pick.sv
module prs_rr_pick #(
    parameter int FW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [(1<<FW)-1:0] req,
    input  logic              allow,
    output logic              gnt_valid,
    output logic [FW-1:0]     gnt_idx
);
    localparam int N = 1 << FW;

    logic [FW-1:0] last_d, last_q;
    logic [FW-1:0] cand;
    logic          found;

    always_comb begin
        found   = 1'b0;
        gnt_idx = '0;
        cand    = '0;
        for (int k = 1; k <= N; k++) begin
            cand = last_q + FW'(k);
            if (!found && req[cand]) begin
                found   = 1'b1;
                gnt_idx = cand;
            end
        end
        gnt_valid = found && allow;
        last_d    = gnt_valid ? gnt_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= FW'(N - 1);
        else        last_q <= last_d;
    end

endmodule

// File: rtl/prs_event_reporter.sv
module prs_event_reporter
    import prs_evt_pkg::*;
#(
    parameter int FUNC_W = 3,
    parameter int GRP_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [FUNC_W-1:0]        issue_func,
    input  logic [GRP_W-1:0]         issue_grp,
    input  logic                     resp_valid,
    input  logic [FUNC_W-1:0]        resp_func,
    input  logic [GRP_W-1:0]         resp_grp,
    input  logic                     resp_fail,
    input  logic [(1<<FUNC_W)-1:0]   func_enable,
    output logic                     evt_valid,
    output logic [FUNC_W-1:0]        evt_func,
    output logic [1:0]               evt_code
);
    localparam int NUM_FUNC = 1 << FUNC_W;

    typedef struct packed {
        logic              valid;
        logic [FUNC_W-1:0] func;
        logic [1:0]        code;
    } port_state_t;

    port_state_t          out_d, out_q;
    logic [NUM_KINDS-1:0] pend [NUM_FUNC];
    logic [NUM_KINDS-1:0] clr  [NUM_FUNC];
    logic [NUM_FUNC-1:0]  any_pend;
    logic                 gnt_valid;
    logic [FUNC_W-1:0]    gnt_idx;
    evt_code_e            gnt_code;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        prs_func_tracker #(.GRP_W(GRP_W)) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_hit  (issue_valid && issue_func == FUNC_W'(f)),
            .req_grp  (issue_grp),
            .rsp_hit  (resp_valid && resp_func == FUNC_W'(f)),
            .rsp_grp  (resp_grp),
            .rsp_fail (resp_fail),
            .enable   (func_enable[f]),
            .clr      (clr[f]),
            .pend     (pend[f])
        );
        assign any_pend[f] = |pend[f];
        assign clr[f] = (gnt_valid && gnt_idx == FUNC_W'(f)) ? kind_onehot(gnt_code) : '0;
    end

    prs_rr_pick #(.FW(FUNC_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (any_pend),
        .allow     (!out_q.valid),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        gnt_code  = pick_kind(pend[gnt_idx]);
        out_d     = '0;
        if (gnt_valid) begin
            out_d.valid = 1'b1;
            out_d.func  = gnt_idx;
            out_d.code  = gnt_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign evt_valid = out_q.valid;
    assign evt_func  = out_q.func;
    assign evt_code  = out_q.code;

endmodule

// File: rtl/prs_event_reporter_chk.sv
module prs_event_reporter_chk #(
    parameter int FUNC_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [(1<<FUNC_W)-1:0] func_enable,
    input logic                   evt_valid,
    input logic [FUNC_W-1:0]      evt_func,
    input logic [1:0]             evt_code
);
    localparam int NF = 1 << FUNC_W;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !evt_valid);  // R1

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);  // R2

    AST_NO_RESERVED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_code != 2'b11);  // R3

    AST_STOP_WHILE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 2'b10) |->
            (($past(func_enable) & ({{(NF-1){1'b0}}, 1'b1} << evt_func)) == '0));  // R8

endmodule

bind prs_event_reporter prs_event_reporter_chk #(.FUNC_W(FUNC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .func_enable (func_enable),
    .evt_valid   (evt_valid),
    .evt_func    (evt_func),
    .evt_code    (evt_code)
);

// File: tb/prs_event_reporter_tb.sv
module prs_event_reporter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid = 1'b0;
    logic [2:0] issue_func = '0;
    logic [2:0] issue_grp = '0;
    logic       resp_valid = 1'b0;
    logic [2:0] resp_func = '0;
    logic [2:0] resp_grp = '0;
    logic       resp_fail = 1'b0;
    logic [7:0] func_enable = '0;
    logic       evt_valid;
    logic [2:0] evt_func;
    logic [1:0] evt_code;

    int vectors = 0;
    int misses = 0;
    bit finished = 0;

    bit [7:0] m_open [8];
    bit       m_enq [8];
    bit       m_armed [8];
    bit [2:0] m_pend [8];
    int       m_last = 7;
    bit       m_prev_v = 0;
    int       ev_cnt [8][3];
    int       order_log [16];
    int       order_n = 0;

    always #2 clk = ~clk;

    prs_event_reporter u_dut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_func(issue_func), .issue_grp(issue_grp),
        .resp_valid(resp_valid), .resp_func(resp_func), .resp_grp(resp_grp),
        .resp_fail(resp_fail), .func_enable(func_enable),
        .evt_valid(evt_valid), .evt_func(evt_func), .evt_code(evt_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick_code(input bit [2:0] el);
        if (el[0]) return 0;
        if (el[1]) return 1;
        return 2;
    endfunction

    task automatic model_reset();
        for (int f = 0; f < 8; f++) begin
            m_open[f] = '0; m_enq[f] = 0; m_armed[f] = 0; m_pend[f] = '0;
        end
        m_last = 7; m_prev_v = 0;
    endtask

    task automatic step();
        bit ev; int ef; int ec; bit [2:0] el; int cnt; bit fall;
        @(negedge clk);
        if (!rst_n) begin
            model_reset();
            chk(evt_valid == 1'b0, "R1 valid in reset", int'(evt_valid), 0);
            return;
        end
        ev = 0; ef = 0; ec = 0;
        if (!m_prev_v) begin
            for (int k = 1; k <= 8; k++) begin
                int f;
                f = (m_last + k) % 8;
                el = {m_pend[f][2] & ~func_enable[f], m_pend[f][1:0]};
                if (!ev && el != 0) begin ev = 1; ef = f; ec = pick_code(el); end
            end
        end
        chk(evt_valid == ev, m_prev_v ? "R2 idle gap" : "R10 valid", int'(evt_valid), int'(ev));
        if (ev) begin
            chk(int'(evt_func) == ef, "R10 func order", int'(evt_func), ef);
            chk(int'(evt_code) == ec, ec == 0 ? "R5 code" : (ec == 1 ? "R6 code" : "R7 code"),
                int'(evt_code), ec);
        end
        if (evt_valid) begin
            ev_cnt[evt_func][evt_code == 2'b11 ? 0 : evt_code]++;
            if (order_n < 16) begin order_log[order_n] = int'(evt_func); order_n++; end
        end
        if (ev) begin m_pend[ef][ec] = 0; m_last = ef; end
        m_prev_v = ev;
        if (resp_valid) begin
            if (m_open[resp_func][resp_grp]) begin
                m_open[resp_func][resp_grp] = 0;
                if (resp_fail) m_pend[resp_func][0] = 1;
            end else m_pend[resp_func][1] = 1;
        end
        if (issue_valid) m_open[issue_func][issue_grp] = 1;
        for (int f = 0; f < 8; f++) begin
            cnt  = $countones(m_open[f]);
            fall = m_enq[f] && !func_enable[f];
            if (func_enable[f]) begin m_armed[f] = 0; m_pend[f][2] = 0; end
            else if ((m_armed[f] || fall) && cnt == 0) begin m_pend[f][2] = 1; m_armed[f] = 0; end
            else if (fall) m_armed[f] = 1;
            m_enq[f] = func_enable[f];
        end
    endtask

    task automatic idle(input int n);
        issue_valid = 0; resp_valid = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_req(input int f, input int g);
        issue_valid = 1; issue_func = 3'(f); issue_grp = 3'(g); resp_valid = 0;
        step();
        issue_valid = 0;
    endtask

    task automatic do_rsp(input int f, input int g, input bit fl);
        resp_valid = 1; resp_func = 3'(f); resp_grp = 3'(g); resp_fail = fl; issue_valid = 0;
        step();
        resp_valid = 0;
    endtask

    initial begin
        int base; int pass_seed; bit [7:0] cur;
        pass_seed = $urandom(32'h5eed_1234);
        rst_n = 0;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1;
        idle(2);
        chk(evt_valid == 0, "R1 quiet after reset", int'(evt_valid), 0);

        // R7: stop waits for drain, then fires once
        func_enable[3] = 1; idle(1);
        do_req(3, 1);
        func_enable[3] = 0; idle(6);
        chk(ev_cnt[3][2] == 0, "R7 no stop while open", ev_cnt[3][2], 0);
        do_rsp(3, 1, 0); idle(4);
        chk(ev_cnt[3][2] == 1, "R7 stop after drain", ev_cnt[3][2], 1);
        chk(ev_cnt[3][0] == 0, "R5 no fail on good rsp", ev_cnt[3][0], 0);
        idle(10);
        chk(ev_cnt[3][2] == 1, "R8 stop only once", ev_cnt[3][2], 1);

        // R8: re-enable before report discards the stop
        func_enable[4] = 1; idle(1);
        do_req(4, 2);
        func_enable[4] = 0; idle(2);
        func_enable[4] = 1; idle(1);
        do_rsp(4, 2, 0); idle(6);
        chk(ev_cnt[4][2] == 0, "R8 discarded while enabled", ev_cnt[4][2], 0);
        func_enable[4] = 0; idle(4);
        chk(ev_cnt[4][2] == 1, "R8 new falling edge", ev_cnt[4][2], 1);

        // R6: unexpected group, fail flag ignored
        do_rsp(5, 6, 1); idle(3);
        chk(ev_cnt[5][1] == 1, "R6 bad group", ev_cnt[5][1], 1);
        chk(ev_cnt[5][0] == 0, "R6 fail ignored", ev_cnt[5][0], 0);

        // R5: failed response closes the group
        do_req(1, 5);
        do_rsp(1, 5, 1); idle(3);
        chk(ev_cnt[1][0] == 1, "R5 fail event", ev_cnt[1][0], 1);
        do_rsp(1, 5, 0); idle(3);
        chk(ev_cnt[1][1] == 1, "R5 group closed", ev_cnt[1][1], 1);

        // R4: duplicate request ignored
        do_req(2, 4); do_req(2, 4);
        do_rsp(2, 4, 0); do_rsp(2, 4, 0); idle(3);
        chk(ev_cnt[2][1] == 1, "R4 duplicate ignored", ev_cnt[2][1], 1);

        // R9 / R10: merge while busy and round-robin order
        idle(4);
        base = order_n;
        do_rsp(0, 7, 0); do_rsp(1, 7, 0); do_rsp(6, 7, 0); do_rsp(6, 7, 0);
        idle(8);
        chk(ev_cnt[6][1] == 1, "R9 merged events", ev_cnt[6][1], 1);
        chk(order_n - base == 3, "R9 pulse count", order_n - base, 3);
        if (order_n - base == 3) begin
            chk(order_log[base] == 0, "R10 first", order_log[base], 0);
            chk(order_log[base+1] == 1, "R10 second", order_log[base+1], 1);
            chk(order_log[base+2] == 6, "R10 third", order_log[base+2], 6);
        end

        // Random phase
        func_enable = 8'hFF;
        for (int i = 0; i < 4000; i++) begin
            issue_valid = ($urandom_range(0, 99) < 40);
            issue_func  = 3'($urandom_range(0, 7));
            issue_grp   = 3'($urandom_range(0, 7));
            resp_valid  = ($urandom_range(0, 99) < 45);
            resp_func   = 3'($urandom_range(0, 7));
            resp_grp    = 3'($urandom_range(0, 7));
            cur = m_open[resp_func];
            if (cur != 0 && $urandom_range(0, 99) < 75) begin
                for (int t = 0; t < 16; t++)
                    if (!cur[resp_grp]) resp_grp = 3'($urandom_range(0, 7));
            end
            resp_fail = ($urandom_range(0, 99) < 30);
            if ($urandom_range(0, 29) == 0)
                func_enable[$urandom_range(0, 7)] ^= 1'b1;
            step();
        end
        idle(40);
        for (int f = 0; f < 8; f++)
            chk(m_pend[f] == 0 || (m_pend[f] == 3'b100 && func_enable[f]),
                "R10 drained", int'(m_pend[f]), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule